// File: doc/BRIEF.md
# I2C Identity EEPROM Target

This block is the target side of a two-wire serial bus for a small EEPROM that carries a factory identity. It serves two address spaces. One is a 256-byte read/write array. The other is a read-only extended space holding a 16-byte serial number and a 6-byte EUI-48 identifier. Both identity values are fixed by parameters. A single byte pointer is shared by all three areas. A controller therefore reaches an identity byte by first loading the pointer with a dummy write (device byte, word address, repeated start) and then reading. A read issued with no new word address continues from wherever the last access left the pointer, whichever area that access touched.

Two write-protect registers, one permanent and one reversible, are modelled as input levels. Either one blocks stores to the lower half of the main array. Software does not read their state as a data byte. Instead it sends a status query, and the target answers it by acknowledging (register clear) or not acknowledging (register set). SCL and SDA arrive already synchronised to the system clock. SDA is open-drain: the block only ever asks for the line to be pulled low.

Device byte encodings: bits 7:4 hold the device-type code, bits 3:1 hold the select bits and bit 0 holds R/W (1 = read). The main array uses code 1010b and the extended space uses code 1011b; in both cases the select bits must equal `dev_pins_i`. Status queries use code 0110b. Select bits 001b query the reversible register; select bits equal to `dev_pins_i` query the permanent register.

Top module: `id_eeprom_target`

## Requirements
- R1: A device byte with code 1010b or 1011b and select bits equal to `dev_pins_i` is acknowledged. Any other code or select value is not acknowledged, and the target leaves SDA released until the next start.
- R2: A dummy write loads the pointer with the word-address byte. A read that follows after a repeated start returns the byte at that address first.
- R3: The pointer is shared by all areas and ends each access at the last byte touched plus one. A read with no word address starts from there, even when the previous access went to the other space.
- R4: In the extended space, addresses 80h–8Fh return the serial number, most significant byte at 80h. Addresses 9Ah–9Fh return the EUI, most significant byte at 9Ah. Every other extended address reads FFh.
- R5: A sequential read in the extended space that passes 9Fh continues at 80h, not at 9Ah.
- R6: In the main array the pointer wraps from FFh to 00h, for sequential reads and for multi-byte writes alike.
- R7: Each data byte written to the main array is acknowledged and the pointer advances by one. When either protect input is 1, bytes aimed at 00h–7Fh are acknowledged but not stored; bytes aimed at 80h–FFh are stored.
- R8: Data bytes written to the extended space are not acknowledged, change no stored data and leave the pointer at the loaded word address.
- R9: A status query with R/W = 1 is acknowledged exactly when the queried register is clear (select 001b gives the reversible one, select equal to `dev_pins_i` gives the permanent one). A query with R/W = 0 is not acknowledged.
- R10: When the controller answers a read byte with NACK, the target releases SDA and drives nothing more until a start. A stop always leaves SDA released.
- R11: SDA is released out of reset, and the target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock, already synchronised |
| sda_i | input | 1 | Bus data level as seen on the wire, synchronised |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| dev_pins_i | input | 3 | Select bits this target answers to |
| prot_perm_i | input | 1 | Permanent protect register programmed |
| prot_rev_i | input | 1 | Reversible protect register programmed |

## Verification
The bench keeps the default 8-bit pointer, so the FFh-to-00h wrap can be reached in a four-byte transfer. It sets select bits 101b, which separates the permanent query from the fixed 001b reversible query. The serial and EUI parameters are given patterns in which all bytes differ. A swapped byte order, a wrong base offset or a rollover to the wrong place therefore shows up as a byte mismatch. One 34-byte read runs from 80h through the undefined gap and the EUI and back into the serial number.

// File: rtl/id_eeprom_pkg.sv
package id_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_RACK
  } tgt_state_e;

  localparam logic [3:0] CODE_MAIN = 4'b1010;
  localparam logic [3:0] CODE_EXT  = 4'b1011;
  localparam logic [3:0] CODE_PROT = 4'b0110;
  localparam logic [2:0] SEL_REV   = 3'b001;

endpackage

// File: rtl/id_line_sense.sv
module id_line_sense (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/id_bram.sv
module id_bram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/id_ext_rom.sv
module id_ext_rom #(
  parameter int AW       = 8,
  parameter int SN_BITS  = 128,
  parameter int EUI_BITS = 48,
  parameter int SN_BASE  = 'h80,
  parameter int EUI_BASE = 'h9A,
  parameter logic [SN_BITS-1:0]  SN_VALUE  = '0,
  parameter logic [EUI_BITS-1:0] EUI_VALUE = '0
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [7:0]    q
);

  localparam int SN_BYTES  = SN_BITS / 8;
  localparam int EUI_BYTES = EUI_BITS / 8;

  function automatic logic [7:0] ext_lookup(input logic [AW-1:0] a_in);
    int a;
    a = int'(a_in);
    if (a >= SN_BASE && a < SN_BASE + SN_BYTES)
      return SN_VALUE[(SN_BYTES - 1 - (a - SN_BASE)) * 8 +: 8];
    else if (a >= EUI_BASE && a < EUI_BASE + EUI_BYTES)
      return EUI_VALUE[(EUI_BYTES - 1 - (a - EUI_BASE)) * 8 +: 8];
    else
      return 8'hFF;
  endfunction

  always_ff @(posedge clk) begin
    q <= ext_lookup(addr);
  end

endmodule

// File: rtl/id_eeprom_target.sv
module id_eeprom_target #(
  parameter int ADDR_W   = 8,
  parameter int SN_BITS  = 128,
  parameter int EUI_BITS = 48,
  parameter int SN_BASE  = 'h80,
  parameter int EUI_BASE = 'h9A,
  parameter logic [SN_BITS-1:0]  SN_VALUE  = 128'h5A01_5A02_5A03_5A04_5A05_5A06_5A07_5A08,
  parameter logic [EUI_BITS-1:0] EUI_VALUE = 48'h02_00_5E_10_20_30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] dev_pins_i,
  input  logic       prot_perm_i,
  input  logic       prot_rev_i
);

  import id_eeprom_pkg::*;

  localparam int EXT_LAST = EUI_BASE + EUI_BITS / 8 - 1;
  localparam logic [ADDR_W-1:0] WRAP_FROM = ADDR_W'(EXT_LAST);
  localparam logic [ADDR_W-1:0] WRAP_TO   = ADDR_W'(SN_BASE);

  logic scl_rise, scl_fall, start_det, stop_det;

  tgt_state_e        state, ret_state;
  logic [6:0]        rx_sh;
  logic [7:0]        tx_sh;
  logic [3:0]        bit_cnt;
  logic              ack_ok;
  logic              ext_sel;
  logic              ctrl_ack;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        ram_q, rom_q, rd_byte, rx_byte;
  logic              ram_we, prot_any, rx_last;
  logic [ADDR_W-1:0] ptr_next;

  id_line_sense u_sense (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  id_bram #(.AW(ADDR_W), .DW(8)) u_array (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ptr),
    .wdata (rx_byte),
    .raddr (ptr),
    .rdata (ram_q)
  );

  id_ext_rom #(
    .AW(ADDR_W), .SN_BITS(SN_BITS), .EUI_BITS(EUI_BITS),
    .SN_BASE(SN_BASE), .EUI_BASE(EUI_BASE),
    .SN_VALUE(SN_VALUE), .EUI_VALUE(EUI_VALUE)
  ) u_ident (
    .clk  (clk),
    .addr (ptr),
    .q    (rom_q)
  );

  assign rx_byte  = {rx_sh, sda_i};
  assign rd_byte  = ext_sel ? rom_q : ram_q;
  assign prot_any = prot_perm_i | prot_rev_i;
  assign rx_last  = scl_rise && (bit_cnt == 4'd7);
  assign ptr_next = (ext_sel && ptr == WRAP_FROM) ? WRAP_TO : ptr + 1'b1;
  assign ram_we   = (state == ST_WDATA) && rx_last && !ext_sel
                    && !(prot_any && !ptr[ADDR_W-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ret_state  <= ST_IDLE;
      rx_sh      <= '0;
      tx_sh      <= '0;
      bit_cnt    <= '0;
      ack_ok     <= 1'b0;
      ext_sel    <= 1'b0;
      ctrl_ack   <= 1'b0;
      ptr        <= '0;
      sda_pull_o <= 1'b0;
    end else if (start_det) begin
      state      <= ST_DEV;
      bit_cnt    <= '0;
      sda_pull_o <= 1'b0;
    end else if (stop_det) begin
      state      <= ST_IDLE;
      sda_pull_o <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_WORD, ST_WDATA: begin
          if (scl_rise) begin
            rx_sh   <= rx_byte[6:0];
            bit_cnt <= bit_cnt + 4'd1;
          end
          if (rx_last) begin
            ack_ok    <= 1'b0;
            ret_state <= ST_IDLE;
            if (state == ST_DEV) begin
              if (rx_byte[3:1] == dev_pins_i &&
                  (rx_byte[7:4] == CODE_MAIN || rx_byte[7:4] == CODE_EXT)) begin
                ack_ok    <= 1'b1;
                ext_sel   <= (rx_byte[7:4] == CODE_EXT);
                ret_state <= rx_byte[0] ? ST_TX : ST_WORD;
              end else if (rx_byte[7:4] == CODE_PROT && rx_byte[0]) begin
                if (rx_byte[3:1] == SEL_REV)         ack_ok <= ~prot_rev_i;
                else if (rx_byte[3:1] == dev_pins_i) ack_ok <= ~prot_perm_i;
              end
            end else if (state == ST_WORD) begin
              ptr       <= rx_byte[ADDR_W-1:0];
              ack_ok    <= 1'b1;
              ret_state <= ST_WDATA;
            end else begin
              ack_ok    <= !ext_sel;
              ret_state <= ST_WDATA;
              if (!ext_sel) ptr <= ptr + 1'b1;
            end
          end else if (scl_fall && bit_cnt == 4'd8) begin
            if (ack_ok) begin
              sda_pull_o <= 1'b1;
              state      <= ST_ACK;
            end else begin
              state      <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            state   <= ret_state;
            if (ret_state == ST_TX) begin
              tx_sh      <= {rd_byte[6:0], 1'b0};
              sda_pull_o <= ~rd_byte[7];
              bit_cnt    <= 4'd1;
              ptr        <= ptr_next;
            end else begin
              sda_pull_o <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              sda_pull_o <= 1'b0;
              state      <= ST_RACK;
            end else begin
              sda_pull_o <= ~tx_sh[7];
              tx_sh      <= {tx_sh[6:0], 1'b0};
              bit_cnt    <= bit_cnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) ctrl_ack <= ~sda_i;
          if (scl_fall) begin
            if (ctrl_ack) begin
              tx_sh      <= {rd_byte[6:0], 1'b0};
              sda_pull_o <= ~rd_byte[7];
              bit_cnt    <= 4'd1;
              ptr        <= ptr_next;
              state      <= ST_TX;
            end else begin
              state      <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/id_eeprom_checker.sv
module id_eeprom_checker #(
  parameter int AW = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      scl_i,
  input logic                      sda_pull_o,
  input logic                      stop_det,
  input logic                      ram_we,
  input logic [AW-1:0]             ptr,
  input logic                      ext_sel,
  input logic                      prot_perm_i,
  input logic                      prot_rev_i,
  input id_eeprom_pkg::tgt_state_e state
);

  import id_eeprom_pkg::*;

  // R11: drive only moves while the bus clock is low
  a_r11_drive_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_i));

  // R11: an idle target keeps the line released
  a_r11_idle_released: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && $past(state) == ST_IDLE) |-> !sda_pull_o);

  // R10: a stop always releases the line
  a_r10_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull_o);

  // R7: no store into the lower half while protected
  a_r7_protected_half_kept: assert property (@(posedge clk) disable iff (rst)
    (ram_we && (prot_perm_i || prot_rev_i)) |-> ptr[AW-1]);

  // R8: the extended space is never written into the array
  a_r8_ext_never_stored: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !ext_sel);

endmodule

bind id_eeprom_target id_eeprom_checker #(.AW(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .scl_i       (scl_i),
  .sda_pull_o  (sda_pull_o),
  .stop_det    (stop_det),
  .ram_we      (ram_we),
  .ptr         (ptr),
  .ext_sel     (ext_sel),
  .prot_perm_i (prot_perm_i),
  .prot_rev_i  (prot_rev_i),
  .state       (state)
);

// File: tb/id_eeprom_target_bench.sv
module id_eeprom_target_bench;

  localparam logic [127:0] SN   = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
  localparam logic [47:0]  EUI  = 48'hA1B2_C3D4_E5F6;
  localparam logic [2:0]   PINS = 3'b101;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic bus_sda = 1'b1;
  logic perm = 1'b0;
  logic rev = 1'b0;
  logic pull;
  wire  sda_line = bus_sda & ~pull;

  always #4 clk = ~clk;

  id_eeprom_target #(.SN_VALUE(SN), .EUI_VALUE(EUI)) u_id_eeprom_target (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sda_pull_o  (pull),
    .dev_pins_i  (PINS),
    .prot_perm_i (perm),
    .prot_rev_i  (rev)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] mem_m [256];
  int  ptr_m = 0;
  bit  ext_m = 1'b0;

  function automatic logic [7:0] ext_model(int a);
    if (a >= 'h80 && a <= 'h8F) return SN[(15 - (a - 'h80)) * 8 +: 8];
    if (a >= 'h9A && a <= 'h9F) return EUI[(5 - (a - 'h9A)) * 8 +: 8];
    return 8'hFF;
  endfunction

  function automatic int next_ptr(int p, bit e);
    if (e && p == 'h9F) return 'h80;
    return (p + 1) % 256;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock reference comparison of the drive against the bus clock (R11)
  logic scl_prev = 1'b1;
  logic pull_prev = 1'b0;
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (scl && scl_prev) check("R11 drive stable while SCL high", int'(pull), int'(pull_prev));
    end
    scl_prev  = scl;
    pull_prev = pull;
  end

  task automatic i2c_start();
    bus_sda = 1'b1; tick(Q);
    scl = 1'b1;     tick(Q);
    bus_sda = 1'b0; tick(Q);
    scl = 1'b0;     tick(Q);
  endtask

  task automatic i2c_stop();
    bus_sda = 1'b0; tick(Q);
    scl = 1'b1;     tick(Q);
    bus_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      bus_sda = b[i]; tick(Q);
      scl = 1'b1;     tick(2 * Q);
      scl = 1'b0;
    end
    bus_sda = 1'b1; tick(Q);
    scl = 1'b1;     tick(Q);
    ack = ~sda_line;
    tick(Q);
    scl = 1'b0;
  endtask

  task automatic recv_byte(bit ack, output logic [7:0] b);
    bus_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl = 1'b0;
    end
    bus_sda = ~ack; tick(Q);
    scl = 1'b1;     tick(2 * Q);
    scl = 1'b0;     tick(1);
    bus_sda = 1'b1;
  endtask

  function automatic logic [7:0] dev(bit e, bit rd);
    return {e ? 4'b1011 : 4'b1010, PINS, rd};
  endfunction

  task automatic read_bytes(bit e, int n, string req);
    logic [7:0] b;
    logic [7:0] exp;
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      exp = e ? ext_model(ptr_m) : mem_m[ptr_m];
      check(req, b, exp);
      ptr_m = next_ptr(ptr_m, e);
    end
    i2c_stop();
  endtask

  task automatic rand_read(bit e, int addr, int n, string req);
    bit a;
    i2c_start(); send_byte(dev(e, 0), a); check({req, " dev ack"}, a, 1);
    send_byte(8'(addr), a); check({req, " word ack"}, a, 1);
    ptr_m = addr; ext_m = e;
    i2c_start(); send_byte(dev(e, 1), a); check({req, " read ack"}, a, 1);
    read_bytes(e, n, req);
  endtask

  task automatic cur_read(bit e, int n, string req);
    bit a;
    ext_m = e;
    i2c_start(); send_byte(dev(e, 1), a); check({req, " read ack"}, a, 1);
    read_bytes(e, n, req);
  endtask

  task automatic wr_main(int addr, int n, int seed, string req);
    bit a;
    logic [7:0] d;
    i2c_start(); send_byte(dev(0, 0), a); check({req, " dev ack"}, a, 1);
    send_byte(8'(addr), a); check({req, " word ack"}, a, 1);
    ptr_m = addr; ext_m = 1'b0;
    for (int i = 0; i < n; i++) begin
      d = 8'((seed + i * 37) % 256);
      send_byte(d, a); check({req, " data ack"}, a, 1);
      if (!((perm || rev) && ptr_m < 'h80)) mem_m[ptr_m] = d;
      ptr_m = (ptr_m + 1) % 256;
    end
    i2c_stop();
  endtask

  task automatic query(logic [2:0] sel, bit rd, int exp_ack, string req);
    bit a;
    i2c_start(); send_byte({4'b0110, sel, rd}, a); check(req, a, exp_ack);
    i2c_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    bit a;
    logic [7:0] b;
    tick(5);
    rst = 1'b0;
    tick(2);
    check("R11 reset releases SDA", pull, 0);

    // R1 addressing
    i2c_start(); send_byte({4'b1010, 3'b100, 1'b0}, a); check("R1 wrong select NACK", a, 0);
    i2c_stop();
    i2c_start(); send_byte({4'b1100, PINS, 1'b1}, a); check("R1 unknown code NACK", a, 0);
    i2c_stop();
    check("R1 line released after NACK", sda_line, 1);

    // R7/R2 page write and random sequential read
    wr_main('h10, 3, 'h40, "R7 write");
    rand_read(0, 'h10, 1, "R2 random read");
    // R10: NACKed read leaves target silent
    cur_read(0, 1, "R3 current read");
    i2c_start(); send_byte(dev(0, 1), a); check("R10 read ack", a, 1);
    recv_byte(0, b); check("R10 byte", b, mem_m[ptr_m]); ptr_m = next_ptr(ptr_m, 0);
    recv_byte(0, b); check("R10 released after NACK", b, 8'hFF);
    i2c_stop();
    wr_main('h13, 1, 'h9C, "R7 write");
    cur_read(0, 1, "R10 pointer after extra clocks");

    // R3 cross-area continuation
    wr_main('h96, 4, 'h11, "R7 write");
    rand_read(0, 'h99, 1, "R3 main read");
    cur_read(1, 1, "R3 ext continues at 9Ah");

    // R4/R5 full ext sweep
    rand_read(1, 'h80, 34, "R4 ext sweep");
    rand_read(1, 'h9A, 8, "R5 ext wrap to 80h");

    // R6 main wrap
    wr_main('hFE, 4, 'h70, "R6 write wrap");
    rand_read(0, 'hFE, 4, "R6 read wrap");

    // R8 ext space is read-only
    i2c_start(); send_byte(dev(1, 0), a); check("R8 dev ack", a, 1);
    send_byte(8'h85, a); check("R8 word ack", a, 1);
    send_byte(8'h00, a); check("R8 data NACK", a, 0);
    i2c_stop();
    ptr_m = 'h85;
    cur_read(1, 1, "R8 serial unchanged");

    // R7 protection
    wr_main('h20, 1, 'h55, "R7 write");
    wr_main('hA0, 1, 'h66, "R7 write");
    rev = 1'b1;
    wr_main('h20, 1, 'h99, "R7 protected write");
    wr_main('hA0, 1, 'h77, "R7 upper write");
    rand_read(0, 'h20, 1, "R7 lower kept (rev)");
    rand_read(0, 'hA0, 1, "R7 upper stored");
    rev = 1'b0; perm = 1'b1;
    wr_main('h20, 1, 'h12, "R7 protected write");
    rand_read(0, 'h20, 1, "R7 lower kept (perm)");
    perm = 1'b0;
    wr_main('h20, 1, 'h22, "R7 write");
    rand_read(0, 'h20, 1, "R7 stored when clear");

    // R9 protect status
    query(3'b001, 1, 1, "R9 rev clear ACK");
    query(PINS, 1, 1, "R9 perm clear ACK");
    rev = 1'b1;
    query(3'b001, 1, 0, "R9 rev set NACK");
    query(PINS, 1, 1, "R9 perm clear with rev set");
    rev = 1'b0; perm = 1'b1;
    query(3'b001, 1, 1, "R9 rev clear with perm set");
    query(PINS, 1, 0, "R9 perm set NACK");
    perm = 1'b0;
    query(3'b001, 0, 0, "R9 write-direction query NACK");
    cur_read(0, 1, "R9 pointer untouched by queries");

    tick(10);
    finish_run();
  end

endmodule